// File: doc/BRIEF.md
# Receive Frame DMA Formatter

This block sits between a receive byte stream and a receive DMA write channel. It gathers each incoming frame into a local buffer. Once the frame has ended, it emits two back-to-back transfers of 32-bit little-endian words. The first transfer is the data buffer. It opens with a 16-bit reported length in the low half of word 0, carries the frame bytes starting at bits [23:16] of word 0, and fills the rest with zeros. The second transfer is the status write. It holds an optional zero checksum word followed by the receive status word. While the block is gathering a frame it also keeps a receive status register and a sticky register, and both are visible as ports.

The control sequencer has five states. IDLE waits for a start-of-frame byte while receive is enabled. FILL stores the bytes that follow. BODY emits the data transfer, one word per cycle. CSUM emits the zero checksum word. STAT emits the status word. The transitions are as follows. IDLE goes to FILL on an accepted start byte, or straight to BODY when that byte also ends the frame. FILL goes to BODY on the end byte. BODY goes to CSUM on its final word when checksum append was latched, and to STAT otherwise. CSUM goes to STAT. STAT goes to IDLE. Input ready is high only in IDLE and FILL, so a following frame waits until the status word has gone out.

Status layout: reported length in bits [LEN_W-1:0], accept flag in bit 16, OK flag in bit 17, completion flag in bit 18. The sticky register uses the same flag positions. The reported length is the stored byte count plus 8, with a floor of 64. The stored byte count saturates at MAX_LEN-8, which caps the reported length at MAX_LEN.

Top module: `rx_dma_framer`

## Requirements
- R1: After reset, in_ready is 1, dma_valid is 0, and rx_status and rx_sticky are 0.
- R2: While rx_en is 0, start bytes are consumed (in_ready stays 1) but start no frame: no DMA word appears and rx_status does not change.
- R3: Data transfer words are little-endian. Word 0 bits [15:0] hold the reported length, and frame byte i sits at buffer byte position i+2 (word (i+2)/4, lane (i+2)%4). Every position past the stored frame bytes is zero.
- R4: The reported length is the stored byte count plus 8, or 64 if that sum is smaller.
- R5: The data transfer has ceil(length/4)+1 words, plus 1 when checksum append is latched. dma_status is 0 on these words and dma_last is 1 only on the final one.
- R6: When the data transfer ends, rx_status takes the reported length in bits [LEN_W-1:0] and sets bits 16 (accept) and 18 (completion), and rx_sticky sets bit 18.
- R7: The status transfer has dma_status=1 and ends with one word equal to rx_status with bit 17 set, carrying dma_last. Afterwards bit 17 is set in both rx_status and rx_sticky.
- R8: csum_en is sampled with the start byte. When it is 1, the status transfer begins with a zero word that has dma_last=0.
- R9: Bytes beyond MAX_LEN-8 are dropped, and the reported length saturates at MAX_LEN.
- R10: in_ready is 0 on every cycle that dma_valid is 1. A frame offered during that time is accepted afterwards and formatted correctly.
- R11: A 0-to-1 change of rx_en clears bit 18 of rx_status and leaves rx_sticky unchanged.
- R12: The first data word appears in the cycle after the end byte is taken. All words of both transfers then follow on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| csum_en | input | 1 | Checksum append enable, sampled at frame start |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Block accepts an input byte |
| dma_valid | output | 1 | DMA word valid |
| dma_data | output | 32 | DMA word, little-endian |
| dma_last | output | 1 | Final word of the current transfer |
| dma_status | output | 1 | 0 for the data transfer, 1 for the status transfer |
| rx_status | output | 32 | Receive status register |
| rx_sticky | output | 32 | Receive sticky register |

## Verification
The bench builds the block with MAX_LEN=96. At that size the truncation and saturation limit (88 stored bytes, length 96) is reached by short frames. Frames just below, at and above the 64-byte floor, frames whose lengths are not word multiples, and frames longer than the limit all fit in a short run. Random frame sizes from 1 to 110 bytes, random checksum append and random input gaps are mixed with directed back-to-back frames and rx_en toggles.

// File: rtl/rx_dma_framer_pkg.sv
package rx_dma_framer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_BODY,
        ST_CSUM,
        ST_STAT
    } fsm_t;

    // flag positions shared by status and sticky registers
    localparam int unsigned FLAG_ACCEPT = 16;
    localparam int unsigned FLAG_OK     = 17;
    localparam int unsigned FLAG_COMP   = 18;

    localparam int unsigned LEN_FLOOR   = 64;
    localparam int unsigned LEN_EXTRA   = 8;   // CRC plus trailer allowance
    localparam int unsigned HDR_BYTES   = 2;   // length prefix in word 0

endpackage

// File: rtl/rx_dma_framer_buf.sv
// Byte-write, word-read frame store. Frame byte i lands at buffer position i+2.
module rx_dma_framer_buf #(
    parameter int unsigned DEPTH = 384,
    parameter int unsigned IDX_W = 11,
    parameter int unsigned KW    = 9
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [KW-1:0]    rd_word,
    output logic [31:0]      rd_data
);
    import rx_dma_framer_pkg::*;

    localparam int unsigned MW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [3:0][7:0] mem [DEPTH];
    logic [IDX_W:0]  pos;
    logic [MW-1:0]   wa;

    assign pos = {1'b0, wr_idx} + (IDX_W+1)'(HDR_BYTES);
    assign wa  = MW'(pos[IDX_W:2]);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wa][pos[1:0]] <= wr_byte;
        end
    end

    always_comb begin
        if (32'(rd_word) < DEPTH) begin
            rd_data = mem[MW'(rd_word)];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/rx_dma_framer_lane.sv
// Builds one output word: keeps only lanes holding stored frame bytes and
// places the reported length into the low half of word 0.
module rx_dma_framer_lane #(
    parameter int unsigned LEN_W = 11,
    parameter int unsigned KW    = 9
) (
    input  logic [KW-1:0]    word_idx,
    input  logic [31:0]      raw,
    input  logic [LEN_W-1:0] nbytes,
    input  logic [LEN_W-1:0] len,
    output logic [31:0]      word
);
    import rx_dma_framer_pkg::*;

    logic [31:0] masked;

    for (genvar j = 0; j < 4; j++) begin : g_lane
        logic [KW+1:0] bpos;
        logic          keep;
        assign bpos = {word_idx, 2'(j)};
        assign keep = (32'(bpos) >= HDR_BYTES) &&
                      (32'(bpos) < 32'(nbytes) + HDR_BYTES);
        assign masked[8*j +: 8] = keep ? raw[8*j +: 8] : 8'h00;
    end

    assign word = (word_idx == '0) ? {masked[31:16], 16'(len)} : masked;

endmodule

// File: rtl/rx_dma_framer_stat.sv
// Receive status and sticky registers.
module rx_dma_framer_stat #(
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned MAX_LEN = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             set_done,
    input  logic             set_ok,
    input  logic [LEN_W-1:0] len,
    output logic [31:0]      stat_q,
    output logic [31:0]      sticky_q
);
    import rx_dma_framer_pkg::*;

    logic        rx_en_q;
    logic        en_rise;
    logic [31:0] stat_d;
    logic [31:0] sticky_d;

    assign en_rise = rx_en & ~rx_en_q;

    always_comb begin
        stat_d   = stat_q;
        sticky_d = sticky_q;
        if (en_rise) begin
            stat_d[FLAG_COMP] = 1'b0;
        end
        if (set_done) begin
            stat_d[LEN_W-1:0]   = len;
            stat_d[FLAG_ACCEPT] = 1'b1;
            stat_d[FLAG_COMP]   = 1'b1;
            sticky_d[FLAG_COMP] = 1'b1;
        end
        if (set_ok) begin
            stat_d[FLAG_OK]   = 1'b1;
            sticky_d[FLAG_OK] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q  <= 1'b0;
            stat_q   <= '0;
            sticky_q <= '0;
        end else begin
            rx_en_q  <= rx_en;
            stat_q   <= stat_d;
            sticky_q <= sticky_d;
        end
    end

    p_ok_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_ok |=> stat_q[FLAG_OK] && sticky_q[FLAG_OK]);

    p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[FLAG_ACCEPT] |-> (32'(stat_q[LEN_W-1:0]) >= LEN_FLOOR) &&
                                (32'(stat_q[LEN_W-1:0]) <= MAX_LEN));

    p_comp_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_en) && !set_done && !set_ok) |=>
            !stat_q[FLAG_COMP] && (sticky_q == $past(sticky_q)));

endmodule

// File: rtl/rx_dma_framer.sv
module rx_dma_framer #(
    parameter int unsigned MAX_LEN = 1536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic        csum_en,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    output logic        in_ready,
    output logic        dma_valid,
    output logic [31:0] dma_data,
    output logic        dma_last,
    output logic        dma_status,
    output logic [31:0] rx_status,
    output logic [31:0] rx_sticky
);
    import rx_dma_framer_pkg::*;

    localparam int unsigned MAXN  = MAX_LEN - LEN_EXTRA;
    localparam int unsigned DEPTH = (MAX_LEN + 3) / 4;
    localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);
    localparam int unsigned KW    = $clog2(DEPTH + 3);

    fsm_t             state_q, state_d;
    logic [LEN_W-1:0] cnt_q;
    logic             cks_q;
    logic [KW-1:0]    k_q;

    logic             beat, sof_take, byte_take, wr_en;
    logic [LEN_W-1:0] wr_idx;
    logic [LEN_W-1:0] len_w;
    logic [KW-1:0]    nw1;
    logic             body_last;
    logic [31:0]      raw_word, body_word;
    logic             set_done, set_ok;

    assign beat      = in_valid & in_ready;
    assign sof_take  = (state_q == ST_IDLE) & beat & in_sof & rx_en;
    assign byte_take = sof_take | ((state_q == ST_FILL) & beat);
    assign wr_idx    = sof_take ? '0 : cnt_q;
    assign wr_en     = byte_take & (32'(wr_idx) < MAXN);

    always_comb begin
        int unsigned sum;
        sum   = 32'(cnt_q) + LEN_EXTRA;
        len_w = LEN_W'((sum < LEN_FLOOR) ? LEN_FLOOR : sum);
    end

    assign nw1       = KW'(((32'(len_w) + 3) >> 2) + 1 + 32'(cks_q));
    assign body_last = (k_q == nw1 - KW'(1));
    assign set_done  = (state_q == ST_BODY) & body_last;
    assign set_ok    = (state_q == ST_STAT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sof_take) state_d = in_eof ? ST_BODY : ST_FILL;
            ST_FILL: if (beat && in_eof) state_d = ST_BODY;
            ST_BODY: if (body_last) state_d = cks_q ? ST_CSUM : ST_STAT;
            ST_CSUM: state_d = ST_STAT;
            ST_STAT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cks_q <= 1'b0;
            k_q   <= '0;
        end else begin
            if (sof_take) begin
                cnt_q <= LEN_W'(1);
                cks_q <= csum_en;
            end else if (byte_take && (32'(cnt_q) < MAXN)) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
            if (state_q == ST_BODY) begin
                k_q <= k_q + KW'(1);
            end else begin
                k_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        dma_valid  = 1'b0;
        dma_last   = 1'b0;
        dma_status = 1'b0;
        dma_data   = '0;
        unique case (state_q)
            ST_IDLE, ST_FILL: in_ready = 1'b1;
            ST_BODY: begin
                dma_valid = 1'b1;
                dma_last  = body_last;
                dma_data  = body_word;
            end
            ST_CSUM: begin
                dma_valid  = 1'b1;
                dma_status = 1'b1;
            end
            ST_STAT: begin
                dma_valid  = 1'b1;
                dma_status = 1'b1;
                dma_last   = 1'b1;
                dma_data   = rx_status | (32'd1 << FLAG_OK);
            end
            default: in_ready = 1'b0;
        endcase
    end

    rx_dma_framer_buf #(.DEPTH(DEPTH), .IDX_W(LEN_W), .KW(KW)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_byte (in_data),
        .rd_word (k_q),
        .rd_data (raw_word)
    );

    rx_dma_framer_lane #(.LEN_W(LEN_W), .KW(KW)) u_lane (
        .word_idx (k_q),
        .raw      (raw_word),
        .nbytes   (cnt_q),
        .len      (len_w),
        .word     (body_word)
    );

    rx_dma_framer_stat #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .set_done (set_done),
        .set_ok   (set_ok),
        .len      (len_w),
        .stat_q   (rx_status),
        .sticky_q (rx_sticky)
    );

    p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid |-> !in_ready);

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_ready_fill_q() && !rx_en) |=> !dma_valid);

    p_status_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_status && dma_last) |=> dma_valid && dma_status);

    p_status_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && dma_status && dma_last) |=> !dma_valid && in_ready);

    p_count_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= MAXN);

    function automatic logic in_ready_fill_q();
        return state_q == ST_FILL;
    endfunction

endmodule

// File: tb/test_rx_dma_framer.sv
module test_rx_dma_framer;

    localparam int unsigned BMAX  = 96;
    localparam int unsigned BMAXN = BMAX - 8;
    localparam logic [31:0] F_ACC  = 32'h0001_0000;
    localparam logic [31:0] F_OK   = 32'h0002_0000;
    localparam logic [31:0] F_COMP = 32'h0004_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, csum_en = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, dma_valid, dma_last, dma_status;
    logic [31:0] dma_data, rx_status, rx_sticky;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ready_bad = 0;
    logic [33:0] got_q[$];
    int          got_t[$];
    logic [33:0] exp_q[$];
    logic [31:0] m_stat = '0;
    logic [31:0] m_sticky = '0;

    always #4 clk = ~clk;

    rx_dma_framer #(.MAX_LEN(BMAX)) i_rx_dma_framer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .csum_en(csum_en),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .dma_valid(dma_valid), .dma_data(dma_data),
        .dma_last(dma_last), .dma_status(dma_status),
        .rx_status(rx_status), .rx_sticky(rx_sticky)
    );

    always @(negedge clk) begin
        cyc++;
        if (dma_valid) begin
            got_q.push_back({dma_status, dma_last, dma_data});
            got_t.push_back(cyc);
            if (in_ready) ready_bad++;
        end
    end

    task automatic check(bit ok, string req, string what, logic [33:0] act, logic [33:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(int n);
        int nn = (n > BMAXN) ? BMAXN : n;
        return (nn + 8 < 64) ? 64 : nn + 8;
    endfunction

    task automatic send_frame(int n, bit cks, bit gaps);
        logic [7:0] bytes[$];
        int nn, len, nw;
        for (int i = 0; i < n; i++) bytes.push_back(8'($urandom));
        if (rx_en) begin
            nn  = (n > BMAXN) ? BMAXN : n;
            len = exp_len(n);
            nw  = (len + 3) / 4 + 1 + int'(cks);
            for (int k = 0; k < nw; k++) begin
                logic [31:0] w;
                for (int j = 0; j < 4; j++) begin
                    int p = 4 * k + j;
                    logic [7:0] b;
                    if (p < 2) b = 8'(len >> (8 * p));
                    else if (p - 2 < nn) b = bytes[p - 2];
                    else b = 8'h00;
                    w[8*j +: 8] = b;
                end
                exp_q.push_back({1'b0, k == nw - 1, w});
            end
            m_stat   = (m_stat & ~32'h0000_FFFF) | F_ACC | F_COMP | 32'(len);
            m_sticky = m_sticky | F_COMP;
            if (cks) exp_q.push_back({1'b1, 1'b0, 32'h0});
            exp_q.push_back({1'b1, 1'b1, m_stat | F_OK});
            m_stat   = m_stat | F_OK;
            m_sticky = m_sticky | F_OK;
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gaps && ($urandom % 4 == 0)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            csum_en  = cks;
            in_valid = 1'b1;
            in_data  = bytes[i];
            in_sof   = (i == 0);
            in_eof   = (i == n - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic drain(string req);
        int guard = 0;
        int gaps = 0;
        while (got_q.size() < exp_q.size() && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        check(got_q.size() == exp_q.size(), "R5", "word count",
              34'(got_q.size()), 34'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            string r = exp_q[i][33] ? (exp_q[i][32] ? "R7" : "R8") : req;
            check(got_q[i] == exp_q[i], r, $sformatf("word %0d", i), got_q[i], exp_q[i]);
        end
        for (int i = 1; i < got_q.size(); i++) begin
            if (!(got_q[i-1][33] && got_q[i-1][32]) && got_t[i] != got_t[i-1] + 1) gaps++;
        end
        check(gaps == 0, "R12", "gapped words", 34'(gaps), 34'd0);
        check(rx_status == m_stat, "R6", "rx_status", 34'(rx_status), 34'(m_stat));
        check(rx_sticky == m_sticky, "R7", "rx_sticky", 34'(rx_sticky), 34'(m_sticky));
        got_q.delete();
        got_t.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "in_ready", 34'(in_ready), 34'd1);
        check(dma_valid == 1'b0, "R1", "dma_valid", 34'(dma_valid), 34'd0);
        check(rx_status == 0 && rx_sticky == 0, "R1", "status regs",
              34'(rx_status | rx_sticky), 34'd0);

        // R2: disabled receive ignores a frame
        send_frame(20, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        check(got_q.size() == 0, "R2", "words while disabled", 34'(got_q.size()), 34'd0);
        check(rx_status == 0, "R2", "status while disabled", 34'(rx_status), 34'd0);
        rx_en = 1'b1;
        @(negedge clk);

        // R4 floor and layout
        send_frame(1, 1'b0, 1'b0);
        drain("R3");
        check(rx_status[6:0] == 7'd64, "R4", "len of 1-byte frame", 34'(rx_status[6:0]), 34'd64);
        send_frame(56, 1'b0, 1'b0);
        drain("R4");
        send_frame(57, 1'b0, 1'b1);
        drain("R4");
        check(rx_status[6:0] == 7'd65, "R4", "len of 57-byte frame", 34'(rx_status[6:0]), 34'd65);
        // R8 checksum append
        send_frame(60, 1'b1, 1'b0);
        drain("R8");
        // R9 saturation and truncation
        send_frame(88, 1'b0, 1'b0);
        drain("R9");
        send_frame(100, 1'b1, 1'b0);
        drain("R9");
        check(rx_status[6:0] == 7'd96, "R9", "saturated len", 34'(rx_status[6:0]), 34'd96);

        // R10 back-to-back frames are held off
        send_frame(30, 1'b0, 1'b0);
        send_frame(10, 1'b1, 1'b0);
        drain("R10");
        check(ready_bad == 0, "R10", "ready high during output", 34'(ready_bad), 34'd0);

        // R11 rx_en rising clears completion only
        @(negedge clk);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        rx_en = 1'b1;
        m_stat = m_stat & ~F_COMP;
        repeat (2) @(negedge clk);
        check(rx_status == m_stat, "R11", "status after enable rise", 34'(rx_status), 34'(m_stat));
        check(rx_sticky == m_sticky, "R11", "sticky after enable rise", 34'(rx_sticky), 34'(m_sticky));

        // random frames
        for (int f = 0; f < 30; f++) begin
            send_frame(1 + int'($urandom % 110), 1'($urandom), 1'b1);
            drain("R3");
        end
        check(ready_bad == 0, "R10", "ready high during output", 34'(ready_bad), 34'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule